// File: doc/BRIEF.md
# Supply Reset and Watchdog Supervisor

This block turns a digital supply-good indication and the activity of a chip-select line into a single processor reset. While the supply flag is low the reset is driven at once. When the flag comes back, the reset is held for a fixed hold-off that is counted in prescaled ticks. Any dip during the hold-off starts the count again. A synchronous power-on reset of the block behaves the same way: the output is active from the first cycle and is released only after the full hold-off with the supply good.

A watchdog also watches the chip-select line. Only a falling edge of the line, taken through a two-flop synchroniser, services it. If the line stays at either level for longer than the selected number of ticks, the watchdog forces the same reset and hold-off. Its counter starts again from zero when that reset is released. A two-bit select chooses one of three timeouts or turns the watchdog off, and a separate enable input gates it as well. A build parameter fixes the polarity of the reset output, and other parameters scale the tick and the hold-off so that short periods can be used in simulation.

Top module: `supply_supervisor`

## Requirements
- R1: While `supply_ok` is 0 the reset output is asserted in the same cycle, with no register delay.
- R2: Once `supply_ok` is high, the reset stays asserted through exactly HOLD_TICKS*CLK_PER_TICK consecutive rising edges that sample `supply_ok`=1. It is released after the last of those edges. A low sample during the hold-off restarts the full count.
- R3: While `rst` is high, and after `rst` falls, the reset output is asserted. With `supply_ok` high, it is released HOLD_TICKS*CLK_PER_TICK rising edges after the first edge at which `rst` is low.
- R4: With ACTIVE_LOW=1, `rst_o` is 0 when the reset is asserted and 1 when it is released. With ACTIVE_LOW=0 the levels are reversed.
- R5: `wd_sel` encoding: 0 selects WD_TICKS0, 1 selects WD_TICKS1, 2 selects WD_TICKS2, and 3 turns the watchdog off.
- R6: With the watchdog active and no falling edge on `cs_n`, the reset is asserted at the T*CLK_PER_TICK-th rising edge after its release, where T is the selected timeout. This holds whether `cs_n` stays high or stays low.
- R7: A falling edge of `cs_n` clears the watchdog count three rising edges after the input change (two synchroniser flops plus the edge flop). A rising edge of `cs_n` has no effect on the count.
- R8: A watchdog-caused reset holds for the same HOLD_TICKS*CLK_PER_TICK edges as a supply-caused one. After release the watchdog times out again after the full selected period.
- R9: With `wd_en`=0, or with `wd_sel`=3, the watchdog never asserts the reset, however long `cs_n` is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block (power-up) |
| supply_ok | input | 1 | Synchronous flag, 1 when the supply is above its threshold |
| cs_n | input | 1 | Chip-select line watched for activity (asynchronous) |
| wd_en | input | 1 | Watchdog enable |
| wd_sel | input | 2 | Watchdog timeout select (see R5) |
| rst_o | output | 1 | Reset output, polarity set by ACTIVE_LOW |

## Verification
The bench targets the exact release edge after a supply rise. A hold-off counter that is off by one tick, or one that resumes instead of restarting after a short dip, releases too early or too late. It also checks the cycle in which the watchdog fires after a release, with `cs_n` stuck high and with it stuck low. If the design serviced the watchdog on a rising edge, the stuck-low case would not fire on time. If a falling edge failed to clear the count, the serviced case would fire at the unserviced time. If the watchdog count kept its value through a watchdog reset, the second timeout would come early. The bench also runs a long, steadily toggled `cs_n` and a disabled watchdog, where any reset at all is an error.

// File: rtl/svr_pkg.sv
package svr_pkg;

    // Timeout select codes of the watchdog
    typedef enum logic [1:0] {
        WDSEL_T0  = 2'd0,
        WDSEL_T1  = 2'd1,
        WDSEL_T2  = 2'd2,
        WDSEL_OFF = 2'd3
    } wd_sel_e;

    // Synchronised chip-select view
    typedef struct packed {
        logic level;
        logic fall;
    } cs_evt_t;

    function automatic int unsigned wd_limit(input wd_sel_e sel,
                                             input int unsigned t0,
                                             input int unsigned t1,
                                             input int unsigned t2);
        case (sel)
            WDSEL_T0: return t0;
            WDSEL_T1: return t1;
            WDSEL_T2: return t2;
            default:  return 0;
        endcase
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic pin_level(input logic asserted, input bit active_low);
        return active_low ? ~asserted : asserted;
    endfunction

endpackage

// File: rtl/svr_tick_gen.sv
module svr_tick_gen #(
    parameter int unsigned CLK_PER_TICK = 100000
) (
    input  logic clk,
    input  logic clear,
    output logic tick
);
    localparam int unsigned PW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_TICK - 1);

    logic [PW-1:0] div_q;

    assign tick = (div_q == LAST);

    always_ff @(posedge clk) begin
        if (clear)
            div_q <= '0;
        else if (tick)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/svr_cs_sync.sv
module svr_cs_sync
    import svr_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n,
    output cs_evt_t evt
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= cs_n;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[STAGES-2:0], cs_n};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= sync_q[STAGES-1];
    end

    assign evt.level = sync_q[STAGES-1];
    assign evt.fall  = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/svr_wdog.sv
module svr_wdog
    import svr_pkg::*;
#(
    parameter int unsigned WD_TICKS0 = 1600,
    parameter int unsigned WD_TICKS1 = 800,
    parameter int unsigned WD_TICKS2 = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       service,
    input  logic       hold,
    input  logic       wd_en,
    input  logic [1:0] wd_sel,
    output logic       fire
);
    localparam int unsigned TMAX = max3(WD_TICKS0, WD_TICKS1, WD_TICKS2);
    localparam int unsigned CW   = $clog2(TMAX + 1);

    wd_sel_e       sel_e;
    int unsigned   limit;
    logic [CW-1:0] lim_m1;
    logic [CW-1:0] cnt_q;
    logic          active;

    assign sel_e  = wd_sel_e'(wd_sel);
    assign limit  = wd_limit(sel_e, WD_TICKS0, WD_TICKS1, WD_TICKS2);
    assign lim_m1 = CW'(limit - 1);
    assign active = wd_en && (sel_e != WDSEL_OFF);

    // A service edge wins over a coinciding tick
    assign fire = active && !hold && !service && tick && (cnt_q == lim_m1);

    always_ff @(posedge clk) begin
        if (rst || hold || !active || service)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= fire ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/svr_holdoff.sv
module svr_holdoff #(
    parameter int unsigned HOLD_TICKS = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic wd_fire,
    input  logic tick,
    output logic restart,
    output logic hold_active
);
    localparam int unsigned HW = $clog2(HOLD_TICKS + 1);
    localparam logic [HW-1:0] HLAST = HW'(HOLD_TICKS - 1);

    logic [HW-1:0] cnt_q;

    assign restart = rst | ~supply_ok | wd_fire;

    always_ff @(posedge clk) begin
        if (restart) begin
            hold_active <= 1'b1;
            cnt_q       <= '0;
        end else if (hold_active && tick) begin
            if (cnt_q == HLAST) begin
                hold_active <= 1'b0;
                cnt_q       <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
    import svr_pkg::*;
#(
    parameter bit          ACTIVE_LOW   = 1'b1,
    parameter int unsigned CLK_PER_TICK = 100000,
    parameter int unsigned HOLD_TICKS   = 200,
    parameter int unsigned WD_TICKS0    = 1600,
    parameter int unsigned WD_TICKS1    = 800,
    parameter int unsigned WD_TICKS2    = 200,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok,
    input  logic       cs_n,
    input  logic       wd_en,
    input  logic [1:0] wd_sel,
    output logic       rst_o
);
    logic    tick;
    logic    restart;
    logic    hold_active;
    logic    wd_fire;
    cs_evt_t cs_evt;

    svr_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
        .clk   (clk),
        .clear (restart),
        .tick  (tick)
    );

    svr_cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .evt  (cs_evt)
    );

    svr_wdog #(
        .WD_TICKS0 (WD_TICKS0),
        .WD_TICKS1 (WD_TICKS1),
        .WD_TICKS2 (WD_TICKS2)
    ) u_wdog (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .service (cs_evt.fall),
        .hold    (hold_active),
        .wd_en   (wd_en),
        .wd_sel  (wd_sel),
        .fire    (wd_fire)
    );

    svr_holdoff #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk         (clk),
        .rst         (rst),
        .supply_ok   (supply_ok),
        .wd_fire     (wd_fire),
        .tick        (tick),
        .restart     (restart),
        .hold_active (hold_active)
    );

    // Supply loss reaches the pin without a register in the path
    assign rst_o = pin_level(hold_active | ~supply_ok, ACTIVE_LOW);
endmodule

module svr_checker #(
    parameter bit ACTIVE_LOW = 1'b1
) (
    input logic       clk,
    input logic       rst,
    input logic       supply_ok,
    input logic       wd_en,
    input logic [1:0] wd_sel,
    input logic       rst_o,
    input logic       hold_active,
    input logic       wd_fire
);
    logic asrt;
    assign asrt = ACTIVE_LOW ? ~rst_o : rst_o;

    assert_supply_low_R1: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |-> asrt);

    assert_release_needs_supply_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(asrt) |-> (supply_ok && $past(supply_ok)));

    assert_powerup_active_R3: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> asrt);

    assert_pin_polarity_R4: assert property (@(posedge clk) disable iff (rst)
        hold_active |-> asrt);

    assert_fire_resets_R8: assert property (@(posedge clk) disable iff (rst)
        wd_fire |=> asrt);

    assert_fire_only_enabled_R9: assert property (@(posedge clk) disable iff (rst)
        wd_fire |-> (wd_en && wd_sel != 2'd3));
endmodule

bind supply_supervisor svr_checker #(.ACTIVE_LOW(ACTIVE_LOW)) u_svr_chk (
    .clk         (clk),
    .rst         (rst),
    .supply_ok   (supply_ok),
    .wd_en       (wd_en),
    .wd_sel      (wd_sel),
    .rst_o       (rst_o),
    .hold_active (hold_active),
    .wd_fire     (wd_fire)
);

// File: tb/tb_supply_supervisor.sv
module tb_supply_supervisor;
    localparam int P   = 4;
    localparam int H   = 6;
    localparam int HP  = H * P;
    localparam int T0  = 3;
    localparam int T1  = 5;
    localparam int T2  = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       supply_ok;
    logic       cs_n;
    logic       wd_en;
    logic [1:0] wd_sel;
    logic       rst_lo;
    logic       rst_hi;

    int cyc    = 0;
    int checks = 0;
    int errors = 0;

    typedef struct {
        int    at;
        bit    asrt;
        string tag;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    supply_supervisor #(
        .ACTIVE_LOW(1'b1), .CLK_PER_TICK(P), .HOLD_TICKS(H),
        .WD_TICKS0(T0), .WD_TICKS1(T1), .WD_TICKS2(T2)
    ) dut (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .cs_n(cs_n),
        .wd_en(wd_en), .wd_sel(wd_sel), .rst_o(rst_lo)
    );

    supply_supervisor #(
        .ACTIVE_LOW(1'b0), .CLK_PER_TICK(P), .HOLD_TICKS(H),
        .WD_TICKS0(T0), .WD_TICKS1(T1), .WD_TICKS2(T2)
    ) dut_hi (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .cs_n(cs_n),
        .wd_en(wd_en), .wd_sel(wd_sel), .rst_o(rst_hi)
    );

    function automatic void expect_at(input int at, input bit asrt, input string tag);
        exp_t e;
        e.at = at; e.asrt = asrt; e.tag = tag;
        q.push_back(e);
    endfunction

    // Monitor: pops expectations as their cycle comes up
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0 && q[0].at <= cyc) begin
                exp_t e;
                e = q.pop_front();
                if (e.at < cyc) begin
                    checks++; errors++;
                    $display("FAIL %s: expectation for cycle %0d missed (now %0d)", e.tag, e.at, cyc);
                end else begin
                    checks++;
                    if (rst_lo !== ~e.asrt) begin
                        errors++;
                        $display("FAIL %s/R4 cycle %0d active-low pin: actual %0b expected %0b",
                                 e.tag, cyc, rst_lo, ~e.asrt);
                    end
                    checks++;
                    if (rst_hi !== e.asrt) begin
                        errors++;
                        $display("FAIL %s/R4 cycle %0d active-high pin: actual %0b expected %0b",
                                 e.tag, cyc, rst_hi, e.asrt);
                    end
                end
            end
        end
    end

    task automatic run_to(input int at);
        while (cyc < at) @(negedge clk);
    endtask

    // Drop supply with a new watchdog setting, return the release cycle
    task automatic restart_with(input logic en, input logic [1:0] sel,
                                input logic csv, output int rel);
        wd_en = en; wd_sel = sel; cs_n = csv; supply_ok = 1'b0;
        repeat (2) @(negedge clk);
        supply_ok = 1'b1;
        rel = cyc + HP;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n0, n1, n2, n3, r, f;
        rst = 1'b1; supply_ok = 1'b1; cs_n = 1'b1; wd_en = 1'b0; wd_sel = 2'd3;
        repeat (3) @(negedge clk);
        expect_at(cyc, 1'b1, "R3");           // asserted during block reset
        rst = 1'b0; n0 = cyc;
        expect_at(n0 + HP - 1, 1'b1, "R3");
        expect_at(n0 + HP, 1'b0, "R3");
        run_to(n0 + HP + 4);

        // Supply dip and restart of the hold-off
        supply_ok = 1'b0; n1 = cyc;
        expect_at(n1, 1'b1, "R1");
        repeat (3) @(negedge clk);
        supply_ok = 1'b1; n2 = cyc;
        run_to(n2 + 10);
        supply_ok = 1'b0;
        expect_at(cyc, 1'b1, "R1");
        repeat (2) @(negedge clk);
        supply_ok = 1'b1; n3 = cyc;
        expect_at(n2 + HP, 1'b1, "R2");       // early release would be wrong
        expect_at(n3 + HP - 1, 1'b1, "R2");
        expect_at(n3 + HP, 1'b0, "R2");
        run_to(n3 + HP + 4);

        // Watchdog off by code 3
        restart_with(1'b1, 2'd3, 1'b1, r);
        expect_at(r - 1, 1'b1, "R9");
        expect_at(r, 1'b0, "R9");
        expect_at(r + 100, 1'b0, "R9");
        run_to(r + 101);

        // Watchdog off by enable
        restart_with(1'b0, 2'd0, 1'b1, r);
        expect_at(r + 60, 1'b0, "R9");
        expect_at(r + 100, 1'b0, "R9");
        run_to(r + 101);

        // Stuck high, code 0, then repeated timeout after watchdog hold
        restart_with(1'b1, 2'd0, 1'b1, r);
        expect_at(r + T0 * P - 1, 1'b0, "R6");
        expect_at(r + T0 * P, 1'b1, "R6");
        f = r + T0 * P;
        expect_at(f + HP - 1, 1'b1, "R8");
        expect_at(f + HP, 1'b0, "R8");
        expect_at(f + HP + T0 * P - 1, 1'b0, "R8");
        expect_at(f + HP + T0 * P, 1'b1, "R8");
        run_to(f + HP + T0 * P + 1);

        // Stuck low with a rising edge, code 1
        restart_with(1'b1, 2'd1, 1'b0, r);
        run_to(r + 8);
        cs_n = 1'b1;
        expect_at(r + T1 * P - 1, 1'b0, "R5");
        expect_at(r + T1 * P, 1'b1, "R7");    // rising edge did not service
        run_to(r + T1 * P + 1);

        // Falling edge service, code 2: clear lands at r+11, fire at r+40
        restart_with(1'b1, 2'd2, 1'b1, r);
        run_to(r + 8);
        cs_n = 1'b0;
        expect_at(r + T2 * P, 1'b0, "R7");
        expect_at(r + 39, 1'b0, "R7");
        expect_at(r + 40, 1'b1, "R7");
        run_to(r + 41);

        // Steady toggling keeps the watchdog quiet, code 0
        restart_with(1'b1, 2'd0, 1'b1, r);
        for (int i = 0; i < 60; i++) begin
            cs_n = ~cs_n;
            if (cyc >= r) expect_at(cyc, 1'b0, "R7");
            repeat (4) @(negedge clk);
        end

        repeat (4) @(negedge clk);
        if (q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: %0d expectations left, expected 0", q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule